// File: doc/BRIEF.md
# Loop Stream Detector with Replay Buffer

This block sits between instruction fetch and decode and watches the fetched stream for a short loop that a backward taken branch closes. It counts how often the same closing branch repeats and checks each pass of the body against a set of size limits. After enough passes it records one pass of the body into a small local buffer. From then on it feeds that body to the decode side over and over, with no gap, while it tells the fetch, branch-prediction and predecode logic that they may idle.

Replay ends as soon as execution reports that the loop was left. The buffer is then discarded and normal fetch resumes on the next cycle. A free-running count of replayed entries serves as a performance counter. A parameter selects a post-decode variant. In that variant the buffer holds 28 micro-ops instead of 18 raw instructions, and only the entry-count and no-call limits apply.

Top module: `lsd_top`

## Requirements
- R1: A taken branch whose target is at or below its own address becomes the candidate loop, and its iteration count restarts at one. A later taken backward branch that differs from the candidate in address or target replaces it and restarts the count. A taken forward branch drops the candidate.
- R2: A loop body qualifies only if it holds at most 18 instructions, counting the closing branch.
- R3: A loop body that holds any call instruction is never captured or replayed.
- R4: A loop body qualifies only if it spans at most 4 lines of 16 bytes. The span runs from the loop start (the branch target) to the last byte of the closing branch (address + length - 1).
- R5: A loop body qualifies only if it holds at most 4 branches, counting the closing branch.
- R6: The loop must be executed more than 64 times before replay. Sixty-five qualifying passes are counted, the 66th pass is captured, and `fetch_idle` and `out_valid` rise one edge after the 66th taken closing branch is sampled. After only 65 passes, neither is high.
- R7: While replaying, `out_valid` is high every cycle. The entries appear in captured order, starting at the loop start, and wrap from the closing branch straight back to the first entry with no idle cycle.
- R8: `fetch_idle` is high exactly while replaying. During that time the fetch inputs are ignored.
- R9: While replaying, `exit_req` makes `out_valid` and `fetch_idle` low after the next edge. No candidate survives, so a further 65 passes are not enough to replay again.
- R10: `deliver_cnt` adds one for every clock edge at which `out_valid` is high. Only reset clears it.
- R11: A not-taken branch at the candidate's closing address drops the candidate, so counting starts over.
- R12: After reset, `out_valid` and `fetch_idle` are low and `deliver_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched instruction present |
| in_addr | input | 32 | Instruction address |
| in_len | input | 4 | Instruction length in bytes |
| in_is_br | input | 1 | Instruction is a branch |
| in_is_call | input | 1 | Instruction is a call |
| in_taken | input | 1 | Branch was taken |
| in_target | input | 32 | Branch target address |
| exit_req | input | 1 | Execution reports that the replayed loop was left |
| out_valid | output | 1 | Replayed entry present |
| out_addr | output | 32 | Replayed instruction address |
| out_len | output | 4 | Replayed instruction length |
| out_is_br | output | 1 | Replayed entry is a branch |
| out_is_call | output | 1 | Replayed entry is a call |
| out_taken | output | 1 | Replayed branch taken |
| out_target | output | 32 | Replayed branch target |
| fetch_idle | output | 1 | Fetch, prediction and predecode may idle |
| deliver_cnt | output | 32 | Count of entries delivered from the buffer |

## Verification
Every result is registered once. The state reached after a closing branch, including the start of replay, shows one edge after that branch is sampled. Replay entry k and a `deliver_cnt` of k show k edges after replay begins, and an exit request takes effect one edge after it is sampled. The bench drives inputs and samples outputs on falling clock edges only. Each check therefore falls after the edge that is due to produce the result and before the next input changes. The threshold is probed at 65 and 66 passes to pin down the exact edge.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    localparam int ADDR_W     = 32;
    localparam int LEN_W      = 4;
    localparam int LINE_SHIFT = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t            addr;
        logic [LEN_W-1:0] len;
        logic             is_br;
        logic             is_call;
        logic             taken;
        addr_t            target;
    } insn_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DETECT  = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_STREAM  = 2'd3
    } lsd_state_e;

    // last byte occupied by an instruction
    function automatic addr_t end_byte(input addr_t a, input logic [LEN_W-1:0] l);
        return a + addr_t'(l) - addr_t'(1);
    endfunction

    // number of aligned fetch lines touched between two byte addresses
    function automatic addr_t lines_touched(input addr_t first, input addr_t last);
        return (last >> LINE_SHIFT) - (first >> LINE_SHIFT) + addr_t'(1);
    endfunction

endpackage

// File: rtl/lsd_body_meter.sv
module lsd_body_meter
    import lsd_pkg::*;
#(
    parameter int MAX_INSNS   = 18,
    parameter int MAX_LINES   = 4,
    parameter int MAX_BRS     = 4,
    parameter bit POST_DECODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             accept,
    input  addr_t            cur_addr,
    input  logic [LEN_W-1:0] cur_len,
    input  logic             cur_is_br,
    input  logic             cur_is_call,
    input  addr_t            start_addr,
    output logic             body_ok
);
    localparam int ICW = $clog2(MAX_INSNS + 2) + 1;
    localparam int BCW = $clog2(MAX_BRS + 2) + 1;
    localparam logic [ICW-1:0] ICAP = ICW'(MAX_INSNS + 1);
    localparam logic [BCW-1:0] BCAP = BCW'(MAX_BRS + 1);

    logic [ICW-1:0] n_insn;
    logic [BCW-1:0] n_br;
    logic           seen_call;

    logic [ICW-1:0] tot_insn;
    logic [BCW-1:0] tot_br;
    logic           any_call;
    addr_t          span;

    // running tallies of the body seen since the last closing branch
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            n_insn    <= '0;
            n_br      <= '0;
            seen_call <= 1'b0;
        end else if (accept) begin
            if (n_insn != ICAP)
                n_insn <= n_insn + ICW'(1);
            if (cur_is_br && (n_br != BCAP))
                n_br <= n_br + BCW'(1);
            if (cur_is_call)
                seen_call <= 1'b1;
        end
    end

    // totals including the instruction on the input (the closing branch)
    always_comb begin
        tot_insn = (n_insn == ICAP) ? ICAP : n_insn + ICW'(1);
        tot_br   = (n_br == BCAP) ? BCAP : n_br + BCW'(cur_is_br);
        any_call = seen_call | cur_is_call;
        span     = lines_touched(start_addr, end_byte(cur_addr, cur_len));
    end

    generate
        if (POST_DECODE) begin : g_uop_limits
            assign body_ok = (tot_insn <= ICW'(MAX_INSNS)) && !any_call;
        end else begin : g_raw_limits
            assign body_ok = (tot_insn <= ICW'(MAX_INSNS)) && !any_call
                          && (tot_br <= BCW'(MAX_BRS))
                          && (span <= addr_t'(MAX_LINES));
        end
    endgenerate

endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
    import lsd_pkg::*;
#(
    parameter int ITER_THRESH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  addr_t      in_addr,
    input  logic       in_is_br,
    input  logic       in_taken,
    input  addr_t      in_target,
    input  logic       exit_req,
    input  logic       body_ok,
    output lsd_state_e state,
    output addr_t      loop_start,
    output logic       meter_clear,
    output logic       meter_accept,
    output logic       buf_clear,
    output logic       buf_write,
    output logic       buf_commit
);
    localparam int IW = $clog2(ITER_THRESH + 1) + 1;

    lsd_state_e     state_q, state_d;
    addr_t          br_q, br_d, tgt_q, tgt_d;
    logic [IW-1:0]  iter_q, iter_d;

    logic tk_any, tk_back, hit_close, miss_close, load_cand;

    always_comb begin
        tk_any     = in_valid && in_is_br && in_taken;
        tk_back    = tk_any && (in_target <= in_addr);
        hit_close  = tk_any && (in_addr == br_q) && (in_target == tgt_q);
        miss_close = in_valid && in_is_br && !in_taken && (in_addr == br_q);
    end

    always_comb begin
        state_d      = state_q;
        br_d         = br_q;
        tgt_d        = tgt_q;
        iter_d       = iter_q;
        meter_clear  = 1'b0;
        meter_accept = 1'b0;
        buf_clear    = 1'b0;
        buf_write    = 1'b0;
        buf_commit   = 1'b0;
        load_cand    = 1'b0;

        case (state_q)
            ST_IDLE: begin
                if (tk_back)
                    load_cand = 1'b1;
            end
            ST_DETECT: begin
                if (in_valid) begin
                    if (hit_close) begin
                        meter_clear = 1'b1;
                        if (!body_ok) begin
                            state_d = ST_IDLE;
                        end else if (iter_q == IW'(ITER_THRESH)) begin
                            state_d   = ST_CAPTURE;
                            buf_clear = 1'b1;
                        end else begin
                            iter_d = iter_q + IW'(1);
                        end
                    end else if (tk_any) begin
                        if (tk_back) load_cand = 1'b1;
                        else         state_d   = ST_IDLE;
                    end else if (miss_close) begin
                        state_d = ST_IDLE;
                    end else begin
                        meter_accept = 1'b1;
                    end
                end
            end
            ST_CAPTURE: begin
                if (in_valid) begin
                    if (hit_close) begin
                        buf_write   = 1'b1;
                        meter_clear = 1'b1;
                        if (body_ok) begin
                            state_d    = ST_STREAM;
                            buf_commit = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else if (tk_any) begin
                        if (tk_back) load_cand = 1'b1;
                        else         state_d   = ST_IDLE;
                    end else if (miss_close) begin
                        state_d = ST_IDLE;
                    end else begin
                        buf_write    = 1'b1;
                        meter_accept = 1'b1;
                    end
                end
            end
            ST_STREAM: begin
                if (exit_req) begin
                    state_d   = ST_IDLE;
                    buf_clear = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (load_cand) begin
            state_d     = ST_DETECT;
            br_d        = in_addr;
            tgt_d       = in_target;
            iter_d      = IW'(1);
            meter_clear = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            br_q    <= '0;
            tgt_q   <= '0;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            br_q    <= br_d;
            tgt_q   <= tgt_d;
            iter_q  <= iter_d;
        end
    end

    assign state      = state_q;
    assign loop_start = tgt_q;

endmodule

// File: rtl/lsd_replay_buf.sv
module lsd_replay_buf
    import lsd_pkg::*;
#(
    parameter int DEPTH = 18
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  write,
    input  logic  commit,
    input  logic  advance,
    input  insn_t wr_data,
    output insn_t rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    insn_t          mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr, len_q;
    logic           room;

    assign room = (wr_ptr < PW'(DEPTH));

    always_ff @(posedge clk) begin
        if (write && room)
            mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            len_q  <= '0;
        end else begin
            if (write && room)
                wr_ptr <= wr_ptr + PW'(1);
            if (commit) begin
                len_q  <= wr_ptr + PW'(1);
                rd_ptr <= '0;
            end else if (advance) begin
                rd_ptr <= (rd_ptr == len_q - PW'(1)) ? '0 : rd_ptr + PW'(1);
            end
        end
    end

    assign rd_data = mem[rd_ptr[AW-1:0]];

endmodule

// File: rtl/lsd_perf_cnt.sv
module lsd_perf_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/lsd_top.sv
module lsd_top
    import lsd_pkg::*;
#(
    parameter bit POST_DECODE = 1'b0,
    parameter int ITER_THRESH = 64,
    parameter int RAW_DEPTH   = 18,
    parameter int UOP_DEPTH   = 28,
    parameter int MAX_LINES   = 4,
    parameter int MAX_BRS     = 4,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_is_br,
    input  logic              in_is_call,
    input  logic              in_taken,
    input  logic [ADDR_W-1:0] in_target,
    input  logic              exit_req,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_is_br,
    output logic              out_is_call,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_target,
    output logic              fetch_idle,
    output logic [CNT_W-1:0]  deliver_cnt
);
    localparam int DEPTH = POST_DECODE ? UOP_DEPTH : RAW_DEPTH;

    lsd_state_e state;
    addr_t      loop_start;
    logic       meter_clear, meter_accept, body_ok;
    logic       buf_clear, buf_write, buf_commit;
    logic       streaming;
    insn_t      fetched, replayed, shown;

    assign fetched = '{addr: in_addr, len: in_len, is_br: in_is_br,
                       is_call: in_is_call, taken: in_taken, target: in_target};

    lsd_ctrl #(.ITER_THRESH(ITER_THRESH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_addr     (in_addr),
        .in_is_br    (in_is_br),
        .in_taken    (in_taken),
        .in_target   (in_target),
        .exit_req    (exit_req),
        .body_ok     (body_ok),
        .state       (state),
        .loop_start  (loop_start),
        .meter_clear (meter_clear),
        .meter_accept(meter_accept),
        .buf_clear   (buf_clear),
        .buf_write   (buf_write),
        .buf_commit  (buf_commit)
    );

    lsd_body_meter #(
        .MAX_INSNS  (DEPTH),
        .MAX_LINES  (MAX_LINES),
        .MAX_BRS    (MAX_BRS),
        .POST_DECODE(POST_DECODE)
    ) u_meter (
        .clk        (clk),
        .rst        (rst),
        .clear      (meter_clear),
        .accept     (meter_accept),
        .cur_addr   (in_addr),
        .cur_len    (in_len),
        .cur_is_br  (in_is_br),
        .cur_is_call(in_is_call),
        .start_addr (loop_start),
        .body_ok    (body_ok)
    );

    assign streaming = (state == ST_STREAM);

    lsd_replay_buf #(.DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .clear  (buf_clear),
        .write  (buf_write),
        .commit (buf_commit),
        .advance(streaming),
        .wr_data(fetched),
        .rd_data(replayed)
    );

    lsd_perf_cnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (streaming),
        .count(deliver_cnt)
    );

    assign shown       = streaming ? replayed : '0;
    assign out_valid   = streaming;
    assign fetch_idle  = streaming;
    assign out_addr    = shown.addr;
    assign out_len     = shown.len;
    assign out_is_br   = shown.is_br;
    assign out_is_call = shown.is_call;
    assign out_taken   = shown.taken;
    assign out_target  = shown.target;

endmodule

// File: rtl/lsd_top_chk.sv
module lsd_top_chk
    import lsd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_is_br,
    input logic              in_taken,
    input logic              exit_req,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [LEN_W-1:0]  out_len,
    input logic              out_is_br,
    input logic              out_is_call,
    input logic              out_taken,
    input logic [ADDR_W-1:0] out_target,
    input logic              fetch_idle,
    input logic [CNT_W-1:0]  deliver_cnt
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> deliver_cnt == $past(deliver_cnt) + CNT_W'(1)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> $stable(deliver_cnt)); // R10
    AST_EXIT_DROP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && exit_req) |=> (!out_valid && !fetch_idle)); // R9
    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !exit_req) |=> out_valid); // R7
    AST_WRAP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !exit_req && out_is_br && out_taken)
        |=> out_addr == $past(out_target)); // R7
    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !exit_req && !(out_is_br && out_taken))
        |=> out_addr == $past(out_addr) + ADDR_W'($past(out_len))); // R7
    AST_NO_CALL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_is_call); // R3
    AST_ENTRY_ON_CLOSE: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_idle) |-> $past(in_valid && in_is_br && in_taken)); // R6
endmodule

bind lsd_top lsd_top_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_is_br   (in_is_br),
    .in_taken   (in_taken),
    .exit_req   (exit_req),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_len    (out_len),
    .out_is_br  (out_is_br),
    .out_is_call(out_is_call),
    .out_taken  (out_taken),
    .out_target (out_target),
    .fetch_idle (fetch_idle),
    .deliver_cnt(deliver_cnt)
);

// File: tb/sim_lsd_top.sv
module sim_lsd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [3:0]  in_len = '0;
    logic        in_is_br = 1'b0;
    logic        in_is_call = 1'b0;
    logic        in_taken = 1'b0;
    logic [31:0] in_target = '0;
    logic        exit_req = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [3:0]  out_len;
    logic        out_is_br;
    logic        out_is_call;
    logic        out_taken;
    logic [31:0] out_target;
    logic        fetch_idle;
    logic [31:0] deliver_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lsd_top u0 (.*);

    typedef struct packed {
        logic [15:0] base;
        logic [5:0]  n;
        logic [3:0]  len;
        logic [5:0]  call_at;
        logic [2:0]  inner;
        logic        expect_stream;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 6'd4,  4'd4, 6'd0, 3'd0, 1'b1, 4'd7},  // R7 plain loop
        '{16'h0200, 6'd18, 4'd2, 6'd0, 3'd0, 1'b1, 4'd2},  // R2 exactly 18
        '{16'h0200, 6'd19, 4'd2, 6'd0, 3'd0, 1'b0, 4'd2},  // R2 19 too many
        '{16'h0180, 6'd5,  4'd4, 6'd3, 3'd0, 1'b0, 4'd3},  // R3 call inside
        '{16'h0300, 6'd8,  4'd8, 6'd0, 3'd0, 1'b1, 4'd4},  // R4 four lines
        '{16'h030C, 6'd8,  4'd8, 6'd0, 3'd0, 1'b0, 4'd4},  // R4 five lines
        '{16'h0400, 6'd6,  4'd4, 6'd0, 3'd3, 1'b1, 4'd5},  // R5 four branches
        '{16'h0400, 6'd6,  4'd4, 6'd0, 3'd4, 1'b0, 4'd5}   // R5 five branches
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [3:0] l, input logic br,
                       input logic call, input logic tk, input logic [31:0] t);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_len = l; in_is_br = br;
        in_is_call = call; in_taken = tk; in_target = t;
    endtask

    task automatic quiet();
        @(negedge clk);
        in_valid = 1'b0; in_is_br = 1'b0; in_taken = 1'b0; in_is_call = 1'b0;
    endtask

    task automatic one_iter(input vec_t v, input logic close_taken);
        for (int i = 0; i < int'(v.n); i++) begin
            logic [31:0] a;
            a = 32'(v.base) + 32'(i) * 32'(v.len);
            if (i == int'(v.n) - 1)
                put(a, v.len, 1'b1, 1'b0, close_taken, 32'(v.base));
            else
                put(a, v.len, (i < int'(v.inner)), (i + 1 == int'(v.call_at)),
                    1'b0, a + 32'(v.len) * 2);
        end
    endtask

    task automatic run(input vec_t v, input int count);
        for (int it = 0; it < count; it++) one_iter(v, 1'b1);
        quiet();
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; exit_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // replay two passes while fetch inputs carry junk, then request exit
    task automatic replay_chk(input vec_t v, input string tag);
        for (int k = 0; k < 2 * int'(v.n); k++) begin
            int idx;
            idx = k % int'(v.n);
            chk(tag, 64'(out_valid), 64'd1);
            chk(tag, 64'(out_addr), 64'(32'(v.base) + 32'(idx) * 32'(v.len)));
            if (idx == int'(v.n) - 1) begin
                chk(tag, 64'(out_taken), 64'd1);
                chk(tag, 64'(out_target), 64'(v.base));
            end
            chk("R10", 64'(deliver_cnt), 64'(k));
            chk("R8", 64'(fetch_idle), 64'd1);
            in_valid = 1'b1; in_addr = 32'h900; in_is_br = 1'b1;
            in_taken = 1'b1; in_target = 32'h800;
            @(negedge clk);
        end
        in_valid = 1'b0; in_is_br = 1'b0; in_taken = 1'b0;
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk("R9", 64'(out_valid), 64'd0);
        chk("R9", 64'(fetch_idle), 64'd0);
        chk("R10", 64'(deliver_cnt), 64'(2 * int'(v.n) + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // table walk: loop shapes against the qualification limits
        for (int vi = 0; vi < NV; vi++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[vi].req);
            do_reset();
            run(VECS[vi], 66);
            chk(tag, 64'(fetch_idle), 64'(VECS[vi].expect_stream));
            if (VECS[vi].expect_stream) replay_chk(VECS[vi], tag);
            else chk(tag, 64'(out_valid), 64'd0);
        end

        // R12 reset state
        do_reset();
        chk("R12", 64'(out_valid), 64'd0);
        chk("R12", 64'(fetch_idle), 64'd0);
        chk("R12", 64'(deliver_cnt), 64'd0);

        // R6 threshold boundary, then R9 exit and R10 count persistence
        run(VECS[0], 65);
        chk("R6", 64'(fetch_idle), 64'd0);
        chk("R6", 64'(out_valid), 64'd0);
        run(VECS[0], 1);
        chk("R6", 64'(fetch_idle), 64'd1);
        replay_chk(VECS[0], "R7");
        run(VECS[0], 65);
        chk("R9", 64'(fetch_idle), 64'd0);
        chk("R10", 64'(deliver_cnt), 64'd9);
        run(VECS[0], 1);
        chk("R9", 64'(fetch_idle), 64'd1);

        // R1 a different backward branch restarts counting
        do_reset();
        run(VECS[0], 40);
        put(32'h500, 4'd4, 1'b1, 1'b0, 1'b1, 32'h480);
        run(VECS[0], 26);
        chk("R1", 64'(fetch_idle), 64'd0);
        run(VECS[0], 40);
        chk("R1", 64'(fetch_idle), 64'd1);

        // R1 a taken forward branch drops the candidate
        do_reset();
        run(VECS[0], 40);
        put(32'h600, 4'd4, 1'b1, 1'b0, 1'b1, 32'h700);
        run(VECS[0], 26);
        chk("R1", 64'(fetch_idle), 64'd0);

        // R11 not-taken closing branch ends the loop
        do_reset();
        run(VECS[0], 30);
        one_iter(VECS[0], 1'b0);
        run(VECS[0], 65);
        chk("R11", 64'(fetch_idle), 64'd0);
        run(VECS[0], 1);
        chk("R11", 64'(fetch_idle), 64'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule